// File: doc/BRIEF.md
# Load Protection Fault Supervisor

This block decides, cycle by cycle, which of a set of load output gates may actually be driven. A serial front end hands it the committed control word together with a one-cycle pulse on each commit; the block combines the requested channel states with a hardware run pin, the supply and temperature comparator flags and per-channel overcurrent and open-load flags, and produces the gate enables plus the status word that the front end shifts back out.

Supply faults, short circuits and thermal shutdown are each timed and latched under their own rules. All delays are counted in strobes of a slow time-base tick (about 32 kHz in the target system), and every limit is a parameter. A commit whose lowest bit is set is the single reset request for all latched faults.

Top module: `lps_supervisor`

## Requirements
- R1: After reset, with a zero control word, all gate enables are low and the status word reads 0x4000. Whenever control bit 15 is low or `hw_enable` is low, all gates are low and status bit 14 is high.
- R2: With no fault latched and no standby, gate i follows control bit i+1 (channels 0..11 at bits 1..12) in the same cycle.
- R3: When `uv_flag` or `ov_flag` stays high for its limit in ticks, all gates go low and status bit 15 goes high on the clock edge that counts the last tick. The undervoltage limit is fixed; the overvoltage limit is the long one when control bit 14 is high and the short one when it is low. Cycles without `tick` do not count.
- R4: Gates return in the same cycle that both supply flags are low again; status bit 15 stays high until a commit with control bit 0 high.
- R5: A supply or overcurrent condition that drops for one clock before its limit is reached restarts its count from zero.
- R6: Overcurrent on a driven channel lasting the short-circuit limit (long when control bit 14 is high, short when low) turns only that channel off and sets status bit 13; both stay set after the overcurrent ends.
- R7: Overcurrent on a driven channel while `prewarn` is high turns that channel off on the next clock edge and sets status bit 13.
- R8: A commit with control bit 0 high clears status bit 13 and releases every channel turned off by short circuit.
- R9: While `tshut` is high all gates are low and all 16 status bits read high; this persists after cooling until a commit with control bit 0 high is made while `tshut` is low.
- R10: With control bit 13 low (open-load detection on), status bit i+1 of a channel whose control bit is low shows its `ol_flag` bit; a channel commanded on shows its gate state. With bit 13 high every channel bit shows its gate state.
- R11: Status bit 0 shows `prewarn` whenever no thermal shutdown is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 16 | Committed control word |
| commit | input | 1 | One-cycle pulse marking a new commit |
| hw_enable | input | 1 | Hardware run pin, low forces standby |
| tick | input | 1 | Time-base strobe for all delays |
| uv_flag | input | 1 | Supply undervoltage comparator |
| ov_flag | input | 1 | Supply overvoltage comparator |
| prewarn | input | 1 | Temperature prewarning comparator |
| tshut | input | 1 | Thermal shutdown comparator |
| oc_flag | input | 12 | Per-channel overcurrent flags |
| ol_flag | input | 12 | Per-channel open-load flags |
| gate_en | output | 12 | Gate enables for the load switches |
| status_word | output | 16 | Status word for the serial front end |

## Verification
Standby, commanded drive, open-load reporting, prewarning and thermal shutdown reach the outputs in the same cycle as the input change, so the bench drives at the falling clock edge and samples a nanosecond later. Supply and short-circuit timers act on the edge that counts the last tick, so each such test checks once after limit-1 counted edges (still on) and once after the limit (off), including a run with the tick present only every third cycle. Short-circuit trips under prewarning and all fault clears take effect one edge after the stimulus and are sampled after exactly that edge.

// File: rtl/lps_pkg.sv
package lps_pkg;

   // control word field positions, derived from the channel count
   function automatic int unsigned f_word_w(input int unsigned nch);
      return nch + 4;
   endfunction

   function automatic int unsigned f_ctl_oldis(input int unsigned nch);
      return nch + 1;
   endfunction

   function automatic int unsigned f_ctl_dsel(input int unsigned nch);
      return nch + 2;
   endfunction

   function automatic int unsigned f_ctl_run(input int unsigned nch);
      return nch + 3;
   endfunction

   // status word field positions
   function automatic int unsigned f_st_scd(input int unsigned nch);
      return nch + 1;
   endfunction

   function automatic int unsigned f_st_stby(input int unsigned nch);
      return nch + 2;
   endfunction

   function automatic int unsigned f_st_psf(input int unsigned nch);
      return nch + 3;
   endfunction

   function automatic int unsigned f_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   typedef struct packed {
      logic run;
      logic dsel;
      logic ol_dis;
      logic rst_req;
   } lps_ctl_t;

endpackage

// File: rtl/lps_delay_timer.sv
module lps_delay_timer #(
   parameter int unsigned LIM_MAX = 16,
   localparam int unsigned CNT_W = $clog2(LIM_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             hit,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   if (LIM_MAX < 1) begin : g_chk_lim
      $error("lps_delay_timer: LIM_MAX must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (tick && (cnt_q < limit)) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // hit: this edge counts the tick that reaches the limit
   assign hit  = run && tick && (({1'b0, cnt_q} + (CNT_W + 1)'(1)) >= {1'b0, limit});
   assign done = run && (cnt_q >= limit);

   a_r5_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> !done);

   a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(LIM_MAX));

endmodule

// File: rtl/lps_channel_guard.sv
module lps_channel_guard #(
   parameter int unsigned LIM_MAX = 16,
   localparam int unsigned CNT_W = $clog2(LIM_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_on,
   input  logic             en_ok,
   input  logic             oc,
   input  logic             prewarn,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   input  logic             clr,
   output logic             gate,
   output logic             trip
);

   logic sc_off_q;
   logic run;
   logic t_hit;
   logic t_done;

   assign gate = cmd_on && en_ok && !sc_off_q;
   assign run  = oc && gate;

   lps_delay_timer #(.LIM_MAX(LIM_MAX)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick),
      .limit (limit),
      .hit   (t_hit),
      .done  (t_done)
   );

   // prewarning short-cuts the delay; done covers a shortened limit
   assign trip = run && (prewarn || t_hit || t_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc_off_q <= 1'b0;
      end else if (trip) begin
         sc_off_q <= 1'b1;
      end else if (clr) begin
         sc_off_q <= 1'b0;
      end
   end

   a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      sc_off_q && !clr |=> sc_off_q);

   a_r7_prewarn_trip: assert property (@(posedge clk) disable iff (!rst_n)
      oc && gate && prewarn |=> !gate);

   a_r8_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !trip |=> !sc_off_q);

endmodule

// File: rtl/lps_status_mux.sv
module lps_status_mux
   import lps_pkg::*;
#(
   parameter int unsigned NCH = 12,
   localparam int unsigned WORD_W = f_word_w(NCH)
) (
   input  logic              tsd_hold,
   input  logic              prewarn,
   input  logic [NCH-1:0]    gate,
   input  logic [NCH-1:0]    cmd,
   input  logic [NCH-1:0]    ol,
   input  logic              ol_en,
   input  logic              scd,
   input  logic              stby,
   input  logic              psf,
   output logic [WORD_W-1:0] word
);

   logic [NCH-1:0] ch_bits;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      // an off channel under open-load detection reports its load flag
      assign ch_bits[i] = (ol_en && !cmd[i]) ? ol[i] : gate[i];
   end

   always_comb begin
      word                  = '0;
      word[0]               = prewarn;
      word[NCH:1]           = ch_bits;
      word[f_st_scd(NCH)]   = scd;
      word[f_st_stby(NCH)]  = stby;
      word[f_st_psf(NCH)]   = psf;
      if (tsd_hold) begin
         word = '1;
      end
   end

endmodule

// File: rtl/lps_supervisor.sv
module lps_supervisor
   import lps_pkg::*;
#(
   parameter int unsigned NCH            = 12,
   parameter int unsigned UV_TICKS       = 448,
   parameter int unsigned OV_LONG_TICKS  = 480,
   parameter int unsigned OV_SHORT_TICKS = 112,
   parameter int unsigned SC_LONG_TICKS  = 3200,
   parameter int unsigned SC_SHORT_TICKS = 400,
   localparam int unsigned WORD_W  = f_word_w(NCH),
   localparam int unsigned SUP_MAX = f_max(UV_TICKS, f_max(OV_LONG_TICKS, OV_SHORT_TICKS)),
   localparam int unsigned SC_MAX  = f_max(SC_LONG_TICKS, SC_SHORT_TICKS),
   localparam int unsigned SUP_W   = $clog2(SUP_MAX + 1),
   localparam int unsigned SC_W    = $clog2(SC_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] ctrl_word,
   input  logic              commit,
   input  logic              hw_enable,
   input  logic              tick,
   input  logic              uv_flag,
   input  logic              ov_flag,
   input  logic              prewarn,
   input  logic              tshut,
   input  logic [NCH-1:0]    oc_flag,
   input  logic [NCH-1:0]    ol_flag,
   output logic [NCH-1:0]    gate_en,
   output logic [WORD_W-1:0] status_word
);

   if (NCH < 1) begin : g_chk_nch
      $error("lps_supervisor: NCH must be at least 1");
   end
   if (UV_TICKS < 1 || OV_LONG_TICKS < 1 || OV_SHORT_TICKS < 1) begin : g_chk_sup
      $error("lps_supervisor: supply limits must be at least 1");
   end
   if (SC_LONG_TICKS < 1 || SC_SHORT_TICKS < 1) begin : g_chk_sc
      $error("lps_supervisor: short-circuit limits must be at least 1");
   end

   localparam logic [SUP_W-1:0] UV_LIM  = SUP_W'(UV_TICKS);
   localparam logic [SUP_W-1:0] OVL_LIM = SUP_W'(OV_LONG_TICKS);
   localparam logic [SUP_W-1:0] OVS_LIM = SUP_W'(OV_SHORT_TICKS);
   localparam logic [SC_W-1:0]  SCL_LIM = SC_W'(SC_LONG_TICKS);
   localparam logic [SC_W-1:0]  SCS_LIM = SC_W'(SC_SHORT_TICKS);

   lps_ctl_t       ctl;
   logic [NCH-1:0] cmd;
   logic           clr;
   logic           stby;
   logic           supply_bad;
   logic [SUP_W-1:0] sup_lim;
   logic [SC_W-1:0]  sc_lim;
   logic           sup_hit;
   logic           supply_off;
   logic           psf_q;
   logic           tsd_q;
   logic           tsd_hold;
   logic           scd_q;
   logic           en_ok;
   logic [NCH-1:0] trip_vec;

   assign ctl.run     = ctrl_word[f_ctl_run(NCH)];
   assign ctl.dsel    = ctrl_word[f_ctl_dsel(NCH)];
   assign ctl.ol_dis  = ctrl_word[f_ctl_oldis(NCH)];
   assign ctl.rst_req = ctrl_word[0];
   assign cmd         = ctrl_word[NCH:1];

   assign clr  = commit && ctl.rst_req;
   assign stby = !ctl.run || !hw_enable;

   // ---------------- supply supervision ----------------
   assign supply_bad = uv_flag || ov_flag;
   assign sup_lim    = uv_flag ? UV_LIM : (ctl.dsel ? OVL_LIM : OVS_LIM);

   lps_delay_timer #(.LIM_MAX(SUP_MAX)) u_sup_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (supply_bad),
      .tick  (tick),
      .limit (sup_lim),
      .hit   (sup_hit),
      .done  (supply_off)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psf_q <= 1'b0;
      end else if (sup_hit || supply_off) begin
         psf_q <= 1'b1;
      end else if (clr) begin
         psf_q <= 1'b0;
      end
   end

   // ---------------- thermal shutdown ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tsd_q <= 1'b0;
      end else if (tshut) begin
         tsd_q <= 1'b1;
      end else if (clr) begin
         tsd_q <= 1'b0;
      end
   end

   assign tsd_hold = tsd_q || tshut;
   assign en_ok    = !stby && !supply_off && !tsd_hold;

   // ---------------- per-channel short-circuit guards ----------------
   assign sc_lim = ctl.dsel ? SCL_LIM : SCS_LIM;

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      lps_channel_guard #(.LIM_MAX(SC_MAX)) u_guard (
         .clk     (clk),
         .rst_n   (rst_n),
         .cmd_on  (cmd[i]),
         .en_ok   (en_ok),
         .oc      (oc_flag[i]),
         .prewarn (prewarn),
         .tick    (tick),
         .limit   (sc_lim),
         .clr     (clr),
         .gate    (gate_en[i]),
         .trip    (trip_vec[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scd_q <= 1'b0;
      end else if (|trip_vec) begin
         scd_q <= 1'b1;
      end else if (clr) begin
         scd_q <= 1'b0;
      end
   end

   // ---------------- status assembly ----------------
   lps_status_mux #(.NCH(NCH)) u_status (
      .tsd_hold (tsd_hold),
      .prewarn  (prewarn),
      .gate     (gate_en),
      .cmd      (cmd),
      .ol       (ol_flag),
      .ol_en    (!ctl.ol_dis),
      .scd      (scd_q),
      .stby     (stby),
      .psf      (psf_q),
      .word     (status_word)
   );

   a_r1_standby_dark: assert property (@(posedge clk) disable iff (!rst_n)
      stby |-> gate_en == '0);

   a_r3_supply_dark: assert property (@(posedge clk) disable iff (!rst_n)
      supply_off |-> (gate_en == '0) && status_word[f_st_psf(NCH)]);

   a_r4_psf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      psf_q && !clr |=> psf_q);

   a_r8_scd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      scd_q && !clr |=> scd_q);

   a_r9_shutdown_dark: assert property (@(posedge clk) disable iff (!rst_n)
      tsd_hold |-> (gate_en == '0) && (status_word == '1));

   a_r9_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      tsd_q && !commit |=> tsd_q);

endmodule

// File: tb/lps_supervisor_test.sv
module lps_supervisor_test;

   localparam int NCH  = 12;
   localparam int UVT  = 6;
   localparam int OVL  = 10;
   localparam int OVS  = 4;
   localparam int SCL  = 12;
   localparam int SCS  = 5;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] ctrl_word;
   logic        commit;
   logic        hw_enable;
   logic        tick;
   logic        uv_flag;
   logic        ov_flag;
   logic        prewarn;
   logic        tshut;
   logic [11:0] oc_flag;
   logic [11:0] ol_flag;
   logic [11:0] gate_en;
   logic [15:0] status_word;

   int errs   = 0;
   int checks = 0;

   always #2 clk = ~clk;

   lps_supervisor #(
      .NCH(NCH), .UV_TICKS(UVT), .OV_LONG_TICKS(OVL), .OV_SHORT_TICKS(OVS),
      .SC_LONG_TICKS(SCL), .SC_SHORT_TICKS(SCS)
   ) uut (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .commit(commit),
      .hw_enable(hw_enable), .tick(tick), .uv_flag(uv_flag), .ov_flag(ov_flag),
      .prewarn(prewarn), .tshut(tshut), .oc_flag(oc_flag), .ol_flag(ol_flag),
      .gate_en(gate_en), .status_word(status_word)
   );

   task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] mkw(input logic [11:0] m, input logic sel,
                                       input logic oldis, input logic run, input logic rst);
      return {run, sel, oldis, m, rst};
   endfunction

   function automatic logic [15:0] exp_st(input logic [11:0] m, input logic [11:0] g,
                                          input logic oldis, input logic [11:0] ol,
                                          input logic pw, input logic stby,
                                          input logic scd, input logic psf);
      logic [11:0] chb;
      for (int i = 0; i < 12; i++) chb[i] = (!oldis && !m[i]) ? ol[i] : g[i];
      return {psf, stby, scd, chb, pw};
   endfunction

   function automatic logic [15:0] w_on(input logic sel);
      return mkw(12'hfff, sel, 1'b1, 1'b1, 1'b0);
   endfunction

   task automatic clear_req(input logic sel);
      ctrl_word = w_on(sel) | 16'h0001;
      commit = 1'b1;
      cyc(1);
      commit = 1'b0;
      ctrl_word = w_on(sel);
      #1;
   endtask

   task automatic ticks(input int n);
      repeat (n) begin
         tick = 1'b1;
         cyc(1);
         tick = 1'b0;
         cyc(2);
      end
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [11:0] m, ol, g;
      logic oldis, run, hw, pw;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; ctrl_word = '0; commit = 1'b0; hw_enable = 1'b1; tick = 1'b1;
      uv_flag = 1'b0; ov_flag = 1'b0; prewarn = 1'b0; tshut = 1'b0;
      oc_flag = '0; ol_flag = '0;
      cyc(3);
      rst_n = 1'b1;
      #1;
      chk("R1 reset gates", {4'h0, gate_en}, 16'h0000);
      chk("R1 reset status", status_word, 16'h4000);

      // random fault-free patterns: R1 R2 R10 R11
      for (int k = 0; k < 60; k++) begin
         cyc(1);
         m = 12'($urandom); ol = 12'($urandom);
         oldis = 1'($urandom); run = ($urandom % 4) != 0; hw = ($urandom % 4) != 0;
         pw = 1'($urandom);
         ctrl_word = mkw(m, 1'($urandom), oldis, run, 1'b0);
         hw_enable = hw; ol_flag = ol; prewarn = pw;
         #1;
         g = (run && hw) ? m : 12'h000;
         chk("R2 R1 random gates", {4'h0, gate_en}, {4'h0, g});
         chk("R10 R11 random status", status_word,
             exp_st(m, g, oldis, ol, pw, !(run && hw), 1'b0, 1'b0));
      end
      cyc(1);
      hw_enable = 1'b1; prewarn = 1'b0; ol_flag = '0;

      // R3 R4 undervoltage with fixed limit
      ctrl_word = w_on(1'b1); uv_flag = 1'b1;
      cyc(UVT - 1); #1;
      chk("R3 uv before limit", {4'h0, gate_en}, 16'h0fff);
      chk("R3 uv psf clear before limit", status_word, 16'h1ffe);
      cyc(1); #1;
      chk("R3 uv gates off", {4'h0, gate_en}, 16'h0000);
      chk("R3 uv psf set", status_word, 16'h8000);
      cyc(1);
      uv_flag = 1'b0; #1;
      chk("R4 uv immediate recovery", {4'h0, gate_en}, 16'h0fff);
      chk("R4 psf sticky", status_word, 16'h9ffe);
      cyc(3); #1;
      chk("R4 psf still sticky", status_word, 16'h9ffe);
      cyc(1);
      clear_req(1'b1);
      chk("R4 psf cleared", status_word, 16'h1ffe);

      // R3 overvoltage short limit with sparse ticks
      cyc(1);
      ctrl_word = w_on(1'b0); ov_flag = 1'b1;
      ticks(OVS - 1); #1;
      chk("R3 ov short not yet", {4'h0, gate_en}, 16'h0fff);
      ticks(1); #1;
      chk("R3 ov short off after sparse ticks", {4'h0, gate_en}, 16'h0000);
      ov_flag = 1'b0; tick = 1'b1;
      cyc(1);
      clear_req(1'b0);
      chk("R4 ov psf cleared", status_word, 16'h1ffe);

      // R5 overvoltage long limit restart
      cyc(1);
      ctrl_word = w_on(1'b1); ov_flag = 1'b1;
      cyc(OVL - 1);
      ov_flag = 1'b0;
      cyc(1);
      ov_flag = 1'b1;
      cyc(OVL - 1); #1;
      chk("R5 ov restart still on", {4'h0, gate_en}, 16'h0fff);
      chk("R5 ov restart no psf", status_word, 16'h1ffe);
      cyc(1); #1;
      chk("R3 ov long off", {4'h0, gate_en}, 16'h0000);
      ov_flag = 1'b0;
      cyc(1);
      clear_req(1'b1);

      // R6 R8 short circuit, short limit, channel 3
      cyc(1);
      ctrl_word = w_on(1'b0); oc_flag = 12'h008;
      cyc(SCS - 1); #1;
      chk("R6 sc before limit", {4'h0, gate_en}, 16'h0fff);
      cyc(1); #1;
      chk("R6 sc channel 3 off only", {4'h0, gate_en}, 16'h0ff7);
      chk("R6 sc flag set", status_word, 16'h3fee);
      cyc(1);
      oc_flag = '0;
      cyc(2); #1;
      chk("R6 sc latched after overcurrent ends", {4'h0, gate_en}, 16'h0ff7);
      cyc(1);
      clear_req(1'b0);
      chk("R8 sc released", {4'h0, gate_en}, 16'h0fff);
      chk("R8 sc flag cleared", status_word, 16'h1ffe);

      // R5 R6 short circuit, long limit, restart on channel 0
      cyc(1);
      ctrl_word = w_on(1'b1); oc_flag = 12'h001;
      cyc(SCL - 1);
      oc_flag = '0;
      cyc(1);
      oc_flag = 12'h001;
      cyc(SCL - 1); #1;
      chk("R5 sc restart still on", {4'h0, gate_en}, 16'h0fff);
      cyc(1); #1;
      chk("R6 sc long channel 0 off", {4'h0, gate_en}, 16'h0ffe);
      cyc(1);
      oc_flag = '0;
      clear_req(1'b1);
      chk("R8 sc long released", {4'h0, gate_en}, 16'h0fff);

      // R7 prewarning short-cut, channel 7
      cyc(1);
      prewarn = 1'b1; oc_flag = 12'h080; #1;
      chk("R7 not before edge", {4'h0, gate_en}, 16'h0fff);
      cyc(1); #1;
      chk("R7 channel 7 off", {4'h0, gate_en}, 16'h0f7f);
      chk("R7 R11 status", status_word, 16'h3eff);
      cyc(1);
      prewarn = 1'b0; oc_flag = '0;
      clear_req(1'b1);
      chk("R8 prewarn trip released", status_word, 16'h1ffe);

      // R9 thermal shutdown
      cyc(1);
      tshut = 1'b1; #1;
      chk("R9 shutdown gates", {4'h0, gate_en}, 16'h0000);
      chk("R9 shutdown status", status_word, 16'hffff);
      cyc(1);
      clear_req(1'b1);
      chk("R9 clear while hot ignored", status_word, 16'hffff);
      cyc(1);
      tshut = 1'b0;
      cyc(2); #1;
      chk("R9 held after cooling", {4'h0, gate_en}, 16'h0000);
      chk("R9 status held after cooling", status_word, 16'hffff);
      cyc(1);
      clear_req(1'b1);
      chk("R9 released", {4'h0, gate_en}, 16'h0fff);
      chk("R9 status released", status_word, 16'h1ffe);

      // R1 hardware standby with word requesting all channels
      cyc(1);
      hw_enable = 1'b0; #1;
      chk("R1 pin standby gates", {4'h0, gate_en}, 16'h0000);
      chk("R1 pin standby status", status_word, 16'h4000);

      finish_run();
   end

endmodule